// File: doc/BRIEF.md
# Stepping Wiper Position Register

This block holds the volatile tap position of a 64-tap digitally controlled resistor array. The stored position is a 6-bit count. A decoder turns it into a one-hot tap select that closes exactly one switch along the array. Position 0 is the low terminal and the all-ones position is the high terminal.

The position has three load sources. A power-up recall copies data register 0 into the count. A direct write from the command engine loads a host-supplied value. A transfer copies any one of the four data registers, chosen by a select field. In step mode, which the command engine enables once an increment/decrement command has been acknowledged and keeps enabled until the stop condition, each high pulse on the bus clock moves the wiper one step. The level of the bus data line during the pulse sets the direction. Stepping stops at the two ends of the array instead of wrapping. The serial protocol decoder and the nonvolatile data registers sit outside this block. The data register contents arrive on a flat input bus, and the bus clock and data samples arrive already synchronised to `clk`.

Top module: `wiper_position_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the position becomes 0 at that edge, and `tap_sel` then equals 1 (bit 0 set).
- R2: `tap_sel` always has exactly one bit set, and the set bit is at index `wiper_pos`. Position 0 sets bit 0 and position 63 sets bit 63.
- R3: A cycle with `recall_req` high loads the lowest field of `bank_data` (bits 5:0, data register 0) into the position at that clock edge.
- R4: A cycle with `wr_req` high loads `wr_data` into the position at that clock edge.
- R5: A cycle with `xfr_req` high loads data register `xfr_sel` into the position. Register k occupies bits `6k+5 : 6k` of `bank_data`.
- R6: With `step_en` high, a cycle in which `bus_scl` is high after being low in the previous cycle, and `bus_sda` is 1, raises the position by one. Holding `bus_scl` high in later cycles gives no further step.
- R7: With `step_en` high, a rising `bus_scl` with `bus_sda` at 0 lowers the position by one.
- R8: A step up at position 63 leaves it at 63, and a step down at 0 leaves it at 0. The count never wraps.
- R9: With `step_en` low and no load request, `bus_scl` pulses leave the position unchanged.
- R10: When requests coincide in one cycle, the priority is recall, then write, then transfer, then step.
- R11: After reset the previous `bus_scl` level is taken as high, so a `bus_scl` that is already high when reset ends does not count as a step pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recall_req | input | 1 | Power-up recall strobe (loads data register 0) |
| wr_req | input | 1 | Direct write strobe |
| wr_data | input | 6 | Value for direct write |
| xfr_req | input | 1 | Transfer strobe from a data register |
| xfr_sel | input | 2 | Data register index for a transfer |
| bank_data | input | 24 | Contents of the four data registers, register k at bits 6k+5:6k |
| step_en | input | 1 | Step mode active |
| bus_scl | input | 1 | Synchronised bus clock sample |
| bus_sda | input | 1 | Synchronised bus data sample (1 = toward high terminal) |
| wiper_pos | output | 6 | Current wiper position |
| tap_sel | output | 64 | One-hot tap select |

## Verification
Every load and every step is taken at the clock edge where its strobe, or the first high `bus_scl` sample, is seen. The new `wiper_pos` and the matching `tap_sel` bit are therefore due one cycle after the stimulus is applied. The driver applies each cycle's stimulus on the falling edge of `clk` and pushes the value its reference model predicts for the next rising edge. The monitor pops that entry 2 ns after the rising edge and compares both outputs, so every check lands exactly one register stage after its stimulus.

// File: rtl/wpr_pkg.sv
// Package: shared types for the wiper position register.
// Assumes: consumers import it before use.
package wpr_pkg;

    // Source that updates the position in a given cycle.
    typedef enum logic [2:0] {
        SRC_HOLD    = 3'd0,
        SRC_RECALL  = 3'd1,
        SRC_WRITE   = 3'd2,
        SRC_XFR     = 3'd3,
        SRC_STEP_UP = 3'd4,
        SRC_STEP_DN = 3'd5
    } wpr_src_e;

endpackage

// File: rtl/wpr_step_detect.sv
// Module: turns synchronised bus clock samples into one step strobe per high pulse.
// Assumes: bus_scl/bus_sda are already synchronised to clk; a reset takes the
// previous clock level as high so no step fires on reset release.
module wpr_step_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic bus_scl,
    input  logic bus_sda,
    output logic step_pulse,
    output logic step_up
);

    logic scl_q;

    // Remember the previous bus clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= bus_scl;
    end

    // One strobe on a low-to-high bus clock while step mode is on.
    always_comb begin
        step_pulse = step_en & bus_scl & ~scl_q;
        step_up    = bus_sda;
    end

endmodule

// File: rtl/wpr_load_mux.sv
// Module: chooses the next wiper position from the prioritised load sources.
// Assumes: at most the highest-priority request in a cycle takes effect;
// stepping saturates at both array ends.
module wpr_load_mux
    import wpr_pkg::*;
#(
    parameter int POS_W    = 6,
    parameter int NUM_BANK = 4,
    parameter int SEL_W    = 2
) (
    input  logic [POS_W-1:0]          cur_pos,
    input  logic                      recall_req,
    input  logic                      wr_req,
    input  logic [POS_W-1:0]          wr_data,
    input  logic                      xfr_req,
    input  logic [SEL_W-1:0]          xfr_sel,
    input  logic [NUM_BANK*POS_W-1:0] bank_data,
    input  logic                      step_pulse,
    input  logic                      step_up,
    output logic [POS_W-1:0]          nxt_pos
);

    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
    localparam logic [POS_W-1:0] POS_MIN = '0;

    wpr_src_e         src;
    logic [POS_W-1:0] bank_pick;

    // Extract the data register addressed by the transfer select.
    always_comb begin
        bank_pick = bank_data[xfr_sel*POS_W +: POS_W];
    end

    // Fixed priority: recall, write, transfer, step.
    always_comb begin
        if (recall_req)      src = SRC_RECALL;
        else if (wr_req)     src = SRC_WRITE;
        else if (xfr_req)    src = SRC_XFR;
        else if (step_pulse) src = step_up ? SRC_STEP_UP : SRC_STEP_DN;
        else                 src = SRC_HOLD;
    end

    // Form the next position, clamping steps at the array ends.
    always_comb begin
        unique case (src)
            SRC_RECALL:  nxt_pos = bank_data[POS_W-1:0];
            SRC_WRITE:   nxt_pos = wr_data;
            SRC_XFR:     nxt_pos = bank_pick;
            SRC_STEP_UP: nxt_pos = (cur_pos == POS_MAX) ? cur_pos : cur_pos + 1'b1;
            SRC_STEP_DN: nxt_pos = (cur_pos == POS_MIN) ? cur_pos : cur_pos - 1'b1;
            default:     nxt_pos = cur_pos;
        endcase
    end

endmodule

// File: rtl/wpr_tap_decoder.sv
// Module: decodes the binary position into a one-hot tap select.
// Assumes: TAPS == 2**POS_W, so every position maps to one tap.
module wpr_tap_decoder #(
    parameter int POS_W = 6,
    parameter int TAPS  = 64
) (
    input  logic [POS_W-1:0] pos,
    output logic [TAPS-1:0]  sel
);

    // One comparator per tap.
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign sel[t] = (pos == t[POS_W-1:0]);
    end

endmodule

// File: rtl/wiper_position_reg.sv
// Module: volatile wiper position register with recall, write, transfer and
// bus-clocked stepping, plus a one-hot tap decode.
// Assumes: inputs are synchronous to clk; protocol decode is done upstream.
module wiper_position_reg #(
    parameter  int POS_W    = 6,
    parameter  int NUM_BANK = 4,
    localparam int TAPS     = 1 << POS_W,
    localparam int SEL_W    = $clog2(NUM_BANK)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      recall_req,
    input  logic                      wr_req,
    input  logic [POS_W-1:0]          wr_data,
    input  logic                      xfr_req,
    input  logic [SEL_W-1:0]          xfr_sel,
    input  logic [NUM_BANK*POS_W-1:0] bank_data,
    input  logic                      step_en,
    input  logic                      bus_scl,
    input  logic                      bus_sda,
    output logic [POS_W-1:0]          wiper_pos,
    output logic [TAPS-1:0]           tap_sel
);

    logic             step_pulse;
    logic             step_up;
    logic [POS_W-1:0] nxt_pos;
    logic [POS_W-1:0] pos_q;

    wpr_step_detect u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .bus_scl    (bus_scl),
        .bus_sda    (bus_sda),
        .step_pulse (step_pulse),
        .step_up    (step_up)
    );

    wpr_load_mux #(
        .POS_W    (POS_W),
        .NUM_BANK (NUM_BANK),
        .SEL_W    (SEL_W)
    ) u_mux (
        .cur_pos    (pos_q),
        .recall_req (recall_req),
        .wr_req     (wr_req),
        .wr_data    (wr_data),
        .xfr_req    (xfr_req),
        .xfr_sel    (xfr_sel),
        .bank_data  (bank_data),
        .step_pulse (step_pulse),
        .step_up    (step_up),
        .nxt_pos    (nxt_pos)
    );

    // Position register, cleared to the low terminal on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= nxt_pos;
    end

    wpr_tap_decoder #(
        .POS_W (POS_W),
        .TAPS  (TAPS)
    ) u_dec (
        .pos (pos_q),
        .sel (tap_sel)
    );

    assign wiper_pos = pos_q;

endmodule

// File: rtl/wpr_checker.sv
// Module: property checker for wiper_position_reg, attached by bind.
// Assumes: same parameters as the bound instance.
module wpr_checker #(
    parameter  int POS_W    = 6,
    parameter  int NUM_BANK = 4,
    localparam int TAPS     = 1 << POS_W,
    localparam int SEL_W    = $clog2(NUM_BANK)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      recall_req,
    input logic                      wr_req,
    input logic [POS_W-1:0]          wr_data,
    input logic                      xfr_req,
    input logic [SEL_W-1:0]          xfr_sel,
    input logic [NUM_BANK*POS_W-1:0] bank_data,
    input logic                      step_en,
    input logic                      bus_scl,
    input logic                      bus_sda,
    input logic [POS_W-1:0]          wiper_pos,
    input logic [TAPS-1:0]           tap_sel
);

    localparam logic [POS_W-1:0] P_MAX = {POS_W{1'b1}};

    logic             c_scl_q;
    logic             c_rise;
    logic             c_load;
    logic [POS_W-1:0] c_bank0;
    logic [POS_W-1:0] c_pick;

    // Independent record of the previous bus clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) c_scl_q <= 1'b1;
        else        c_scl_q <= bus_scl;
    end

    // Helper terms for the properties.
    always_comb begin
        c_rise  = step_en && bus_scl && !c_scl_q;
        c_load  = recall_req || wr_req || xfr_req;
        c_bank0 = bank_data[POS_W-1:0];
        c_pick  = '0;
        for (int k = 0; k < NUM_BANK; k++)
            if (xfr_sel == k[SEL_W-1:0]) c_pick = bank_data[k*POS_W +: POS_W];
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> wiper_pos == '0);

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

    p_recall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> wiper_pos == $past(c_bank0));

    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !recall_req) |=> wiper_pos == $past(wr_data));

    p_xfr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfr_req && !wr_req && !recall_req) |=> wiper_pos == $past(c_pick));

    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_load && c_rise && bus_sda && wiper_pos != P_MAX) |=> wiper_pos == $past(wiper_pos) + 1'b1);

    p_step_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_load && c_rise && !bus_sda && wiper_pos != '0) |=> wiper_pos == $past(wiper_pos) - 1'b1);

    p_sat_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_load && c_rise && bus_sda && wiper_pos == P_MAX) |=> wiper_pos == P_MAX);

    p_sat_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_load && c_rise && !bus_sda && wiper_pos == '0) |=> wiper_pos == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_load && !c_rise) |=> $stable(wiper_pos));

endmodule

bind wiper_position_reg wpr_checker #(.POS_W(POS_W), .NUM_BANK(NUM_BANK)) u_chk (.*);

// File: tb/wiper_position_reg_bench.sv
// Scoreboard bench: the driver predicts, the monitor compares one cycle later.
module wiper_position_reg_bench;

    localparam int POS_W = 6;
    localparam int NB    = 4;
    localparam int TAPS  = 1 << POS_W;

    typedef struct {
        logic [POS_W-1:0] pos;
        string            tag;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  recall_req = 1'b0;
    logic                  wr_req = 1'b0;
    logic [POS_W-1:0]      wr_data = '0;
    logic                  xfr_req = 1'b0;
    logic [1:0]            xfr_sel = '0;
    logic [NB*POS_W-1:0]   bank_data;
    logic                  step_en = 1'b0;
    logic                  bus_scl = 1'b0;
    logic                  bus_sda = 1'b0;
    logic [POS_W-1:0]      wiper_pos;
    logic [TAPS-1:0]       tap_sel;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t q[$];

    // Reference model state.
    logic [POS_W-1:0] m_pos = '0;
    logic             m_scl = 1'b1;

    always #5 clk = ~clk;

    // Data registers: DR0=0x15, DR1=0x2A, DR2=0x05, DR3=0x3C.
    assign bank_data = {6'h3C, 6'h05, 6'h2A, 6'h15};

    wiper_position_reg u_wiper_position_reg (
        .clk(clk), .rst_n(rst_n), .recall_req(recall_req), .wr_req(wr_req),
        .wr_data(wr_data), .xfr_req(xfr_req), .xfr_sel(xfr_sel),
        .bank_data(bank_data), .step_en(step_en), .bus_scl(bus_scl),
        .bus_sda(bus_sda), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    // Driver: applies one cycle of stimulus and pushes the predicted result.
    task automatic drive(input logic rst, input logic rec, input logic wr,
                         input logic [POS_W-1:0] wd, input logic xf,
                         input logic [1:0] sel, input logic sen,
                         input logic scl, input logic sda, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = rst; recall_req = rec; wr_req = wr; wr_data = wd;
        xfr_req = xf; xfr_sel = sel; step_en = sen; bus_scl = scl; bus_sda = sda;
        if (!rst) begin
            m_pos = '0; m_scl = 1'b1;
        end else begin
            if (rec)     m_pos = bank_data[POS_W-1:0];
            else if (wr) m_pos = wd;
            else if (xf) m_pos = bank_data[sel*POS_W +: POS_W];
            else if (sen && scl && !m_scl) begin
                if (sda)  m_pos = (m_pos == 6'h3F) ? m_pos : m_pos + 6'd1;
                else      m_pos = (m_pos == 6'h00) ? m_pos : m_pos - 6'd1;
            end
            m_scl = scl;
        end
        e.pos = m_pos; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(1, 0, 0, '0, 0, '0, step_en, bus_scl, bus_sda, tag);
    endtask

    // One bus clock pulse in step mode: low cycle then high cycle.
    task automatic pulse(input logic sen, input logic sda, input string tag);
        drive(1, 0, 0, '0, 0, '0, sen, 1'b0, sda, tag);
        drive(1, 0, 0, '0, 0, '0, sen, 1'b1, sda, tag);
    endtask

    // Monitor: compares each prediction one register stage after its stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (wiper_pos !== e.pos) begin
                    fails++;
                    $display("FAIL %s: wiper_pos actual %h expected %h", e.tag, wiper_pos, e.pos);
                end
                checks++;
                if (tap_sel !== (64'd1 << e.pos)) begin
                    fails++;
                    $display("FAIL %s/R2: tap_sel actual %h expected %h", e.tag, tap_sel, 64'd1 << e.pos);
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        // R1: reset clears to the low terminal.
        drive(0, 0, 0, '0, 0, '0, 0, 1, 0, "R1");
        drive(0, 0, 0, '0, 0, '0, 0, 1, 0, "R1");
        // R11: bus clock already high at reset release gives no step.
        drive(1, 0, 0, '0, 0, '0, 1, 1, 1, "R11");
        drive(1, 0, 0, '0, 0, '0, 0, 0, 0, "R11");
        // R3: recall loads DR0.
        drive(1, 1, 0, '0, 0, '0, 0, 0, 0, "R3");
        idle("R3");
        // R4: direct write.
        drive(1, 0, 1, 6'h3E, 0, '0, 0, 0, 0, "R4");
        // R6: step up, then holding the clock high adds nothing.
        pulse(1, 1, "R6");
        drive(1, 0, 0, '0, 0, '0, 1, 1, 1, "R6");
        // R8: step up at the high end holds 63 (R2: tap bit 63).
        pulse(1, 1, "R8");
        // R5: transfer from data registers 2 and 3.
        drive(1, 0, 0, '0, 1, 2'd2, 1, 0, 0, "R5");
        drive(1, 0, 0, '0, 1, 2'd3, 0, 0, 0, "R5");
        drive(1, 0, 0, '0, 1, 2'd2, 0, 0, 0, "R5");
        // R7: step down twice.
        pulse(1, 0, "R7");
        pulse(1, 0, "R7");
        // R8: step down at the low end holds 0.
        drive(1, 0, 1, 6'h01, 0, '0, 1, 0, 0, "R8");
        pulse(1, 0, "R8");
        pulse(1, 0, "R8");
        pulse(1, 1, "R6");
        // R9: pulses without step mode have no effect.
        pulse(0, 1, "R9");
        pulse(0, 0, "R9");
        pulse(0, 1, "R9");
        // R10: priority between coincident requests.
        drive(1, 1, 1, 6'h33, 1, 2'd3, 1, 0, 1, "R10");
        drive(1, 0, 1, 6'h33, 1, 2'd3, 1, 1, 1, "R10");
        drive(1, 0, 0, '0, 1, 2'd1, 1, 0, 1, "R10");
        drive(1, 0, 0, '0, 1, 2'd3, 1, 1, 0, "R10");
        drive(1, 0, 0, '0, 0, '0, 1, 0, 0, "R10");
        idle("R9");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule